// File: doc/BRIEF.md
# Square-Wave Tone and Noise Channel Mixer

This block produces the raw per-channel amplitude codes of a three-voice programmable sound source. Each voice has a square-wave tone generator whose half-period is set by a 12-bit period value. All three voices share one pseudo-random noise source whose shift rate comes from a 5-bit period value. A per-voice gate combines tone and noise under two active-low enable bits. A volume field then picks either a fixed 4-bit level or an externally supplied envelope level. The result is three 4-bit amplitude codes. Analog conversion, logarithmic scaling and envelope shaping belong to neighbouring blocks.

A clock enable qualifies all timing. A shared prescaler turns eight enabled clocks into one internal step. The tone dividers run on that step, and the noise divider runs on every second step. The configuration inputs are plain level-sensitive control pins that are sampled on every clock. The outputs are continuous registered levels, so the block has no handshake and no back-pressure. A downstream block simply samples the amplitude codes.

Top module: `sqm_tone_mixer`

## Requirements
- R1: With the clock enable held high, each tone output is a square wave: it stays high for 8*P clocks and completes a full cycle in 16*P clocks, where P is the channel's 12-bit period. Every clock with the enable low stretches this time by one clock.
- R2: A tone or noise period of 0 behaves exactly like a period of 1.
- R3: While the clock enable is low, no tone or noise state advances, so the amplitude outputs hold their values.
- R4: Noise comes from a 17-bit shift register that resets to 1. On each shift, the register moves right by one and bit 16 takes bit 0 XOR bit 3. The noise bit is bit 0. The first shift occurs 16*N enabled clocks after reset, and later shifts follow every 16*N enabled clocks, where N is the 5-bit noise period.
- R5: In `mix_off`, bits 0, 1 and 2 disable tone on channels A, B and C, and bits 3, 4 and 5 disable noise on channels A, B and C. A value of 1 disables the source and 0 enables it.
- R6: A channel's gate is (tone bit OR tone-disable) AND (noise bit OR noise-disable). The amplitude is the selected level when the gate is 1 and 0 when it is 0.
- R7: In a 5-bit volume input, bit 4 = 1 selects `env_lvl` and ignores bits 3..0. Bit 4 = 0 selects bits 3..0 as a fixed level.
- R8: The amplitude outputs are registered: a change of a volume, envelope or mixer input appears on the outputs one clock after it is applied.
- R9: During reset, all amplitude outputs are 0. After reset, the tone bits start at 0 and the noise bit starts at 1.
- R10: The three tone channels divide independently, each by its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable qualifying all counters |
| tone_per_a | input | 12 | Tone period, channel A |
| tone_per_b | input | 12 | Tone period, channel B |
| tone_per_c | input | 12 | Tone period, channel C |
| noise_per | input | 5 | Noise period |
| mix_off | input | 6 | Active-high disables: [2:0] tone A/B/C, [5:3] noise A/B/C |
| vol_a | input | 5 | Channel A volume: bit 4 envelope select, [3:0] level |
| vol_b | input | 5 | Channel B volume |
| vol_c | input | 5 | Channel C volume |
| env_lvl | input | 4 | Current envelope level |
| amp_a | output | 4 | Channel A amplitude code |
| amp_b | output | 4 | Channel B amplitude code |
| amp_c | output | 4 | Channel C amplitude code |

## Verification
The hardest situation to reach from the ports is a known combination of tone phase and noise bit under a given mixer setting. The phases run freely and are not visible once both sources pass through the gate. To get there, the bench resets the block before each of the 64 mixer settings, with small tone and noise periods. Reset aligns every divider and the shift register to a known phase. The bench then derives the tone bit and the shift count from the elapsed clock count, and steps its own model of the shift register forward. Period measurement uses edge-to-edge intervals at the outputs, so it does not depend on the output latency.

// File: rtl/sqm_pkg.sv
package sqm_pkg;
  localparam int NUM_CH     = 3;
  localparam int LFSR_W     = 17;
  localparam int LFSR_TAP   = 3;
  localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

  // feedback of bit 0 and the tap enters at the top, register shifts right
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[LFSR_TAP], s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/sqm_prescaler.sv
module sqm_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  output logic step,
  output logic half_step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          half_q;

  assign step      = clk_en && (cnt == LAST);
  assign half_step = step && half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      half_q <= 1'b0;
    end else if (clk_en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
      if (step) half_q <= ~half_q;
    end
  end

  // R3: a disabled clock never produces a step
  p_no_step_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !step);
  // R1: steps are spaced by the division ratio, never back to back
  p_step_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
  // R4: the noise rate is half the step rate
  p_half_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half_step |=> !half_step);
endmodule

// File: rtl/sqm_divider.sv
module sqm_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff;
  logic [W:0]   nxt;

  // a zero period is treated as one
  assign eff = (period == '0) ? W'(1) : period;
  assign nxt = {1'b0, cnt} + (W+1)'(1);
  // >= lets a period lowered below the running count recover at once
  assign hit = step && (nxt >= {1'b0, eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= hit ? '0 : nxt[W-1:0];
  end

  // R1: a terminal count restarts the divider from zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
  // R3: without a step the count does not move
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
  // R2: with period 0 or 1 every step ends a count
  p_min_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (period <= W'(1))) |-> hit);
endmodule

// File: rtl/sqm_lfsr.sv
module sqm_lfsr
  import sqm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic bit_out
);
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= LFSR_SEED;
    else if (adv) state <= lfsr_next(state);
  end

  assign bit_out = state[0];

  // R4: the register never falls into the all-zero lock state
  p_lfsr_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R4: the register only moves on a noise tick
  p_lfsr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
endmodule

// File: rtl/sqm_chan_gate.sv
module sqm_chan_gate #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_bit,
  input  logic             noise_bit,
  input  logic             tone_off,
  input  logic             noise_off,
  input  logic [LVL_W:0]   vol,
  input  logic [LVL_W-1:0] env,
  output logic [LVL_W-1:0] amp
);
  logic             gate;
  logic [LVL_W-1:0] level;

  assign gate  = (tone_bit | tone_off) & (noise_bit | noise_off);
  assign level = vol[LVL_W] ? env : vol[LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp <= '0;
    else        amp <= gate ? level : '0;
  end

  // R6: a closed gate silences the channel on the next clock
  p_closed_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (amp == '0));
  // R7: envelope mode follows the envelope input one clock later
  p_env_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && vol[LVL_W]) |=> (amp == $past(env)));
  // R8: with every source disabled the fixed level passes after one clock
  p_fixed_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_off && noise_off && !vol[LVL_W]) |=> (amp == $past(vol[LVL_W-1:0])));
endmodule

// File: rtl/sqm_tone_mixer.sv
module sqm_tone_mixer
  import sqm_pkg::*;
#(
  parameter int TONE_W  = 12,
  parameter int NOISE_W = 5,
  parameter int LVL_W   = 4,
  parameter int PRE_DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic [TONE_W-1:0]  tone_per_a,
  input  logic [TONE_W-1:0]  tone_per_b,
  input  logic [TONE_W-1:0]  tone_per_c,
  input  logic [NOISE_W-1:0] noise_per,
  input  logic [2*NUM_CH-1:0] mix_off,
  input  logic [LVL_W:0]     vol_a,
  input  logic [LVL_W:0]     vol_b,
  input  logic [LVL_W:0]     vol_c,
  input  logic [LVL_W-1:0]   env_lvl,
  output logic [LVL_W-1:0]   amp_a,
  output logic [LVL_W-1:0]   amp_b,
  output logic [LVL_W-1:0]   amp_c
);
  logic step, half_step;
  logic noise_hit, noise_bit;

  logic [TONE_W-1:0] per_arr  [NUM_CH];
  logic [LVL_W:0]    vol_arr  [NUM_CH];
  logic [LVL_W-1:0]  amp_arr  [NUM_CH];
  logic [NUM_CH-1:0] tone_hit;
  logic [NUM_CH-1:0] tone_q;

  assign per_arr[0] = tone_per_a;
  assign per_arr[1] = tone_per_b;
  assign per_arr[2] = tone_per_c;
  assign vol_arr[0] = vol_a;
  assign vol_arr[1] = vol_b;
  assign vol_arr[2] = vol_c;
  assign amp_a = amp_arr[0];
  assign amp_b = amp_arr[1];
  assign amp_c = amp_arr[2];

  sqm_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .step(step), .half_step(half_step)
  );

  sqm_divider #(.W(NOISE_W)) u_noise_div (
    .clk(clk), .rst_n(rst_n), .step(half_step),
    .period(noise_per), .hit(noise_hit)
  );

  sqm_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(noise_hit), .bit_out(noise_bit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    sqm_divider #(.W(TONE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .step(step),
      .period(per_arr[ch]), .hit(tone_hit[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tone_q[ch] <= 1'b0;
      else if (tone_hit[ch]) tone_q[ch] <= ~tone_q[ch];
    end

    sqm_chan_gate #(.LVL_W(LVL_W)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .tone_bit(tone_q[ch]), .noise_bit(noise_bit),
      .tone_off(mix_off[ch]), .noise_off(mix_off[NUM_CH + ch]),
      .vol(vol_arr[ch]), .env(env_lvl), .amp(amp_arr[ch])
    );

    // R1: the square wave only changes at a terminal count
    p_tone_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_hit[ch] |=> $stable(tone_q[ch]));
    // R3: a frozen clock keeps the tone phase
    p_tone_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(tone_q[ch]));
  end
endmodule

// File: tb/sqm_tone_mixer_test.sv
module sqm_tone_mixer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic [11:0] tone_per_a = '0, tone_per_b = '0, tone_per_c = '0;
  logic [4:0]  noise_per = '0;
  logic [5:0]  mix_off = 6'h3f;
  logic [4:0]  vol_a = '0, vol_b = '0, vol_c = '0;
  logic [3:0]  env_lvl = '0;
  logic [3:0]  amp_a, amp_b, amp_c;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int en_mode = 0;   // 0: always on, 1: every other clock, 2: off
  bit done = 0;

  sqm_tone_mixer uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .tone_per_a(tone_per_a), .tone_per_b(tone_per_b), .tone_per_c(tone_per_c),
    .noise_per(noise_per), .mix_off(mix_off),
    .vol_a(vol_a), .vol_b(vol_b), .vol_c(vol_c), .env_lvl(env_lvl),
    .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (en_mode == 0)      clk_en = 1'b1;
    else if (en_mode == 1) clk_en = ~clk_en;
    else                   clk_en = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int amp_of(input int c);
    case (c)
      0: return int'(amp_a);
      1: return int'(amp_b);
      default: return int'(amp_c);
    endcase
  endfunction

  function automatic logic [16:0] lfsr_step(input logic [16:0] s);
    return {s[0] ^ s[3], s[16:1]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  // wait for a rising (rise=1) or falling edge of a channel's amplitude
  task automatic wait_edge(input int c, input bit rise, output int t);
    int prev;
    prev = amp_of(c);
    t = -1;
    for (int g = 0; g < 20000; g++) begin
      tick(1);
      if (rise ? (prev == 0 && amp_of(c) != 0) : (prev != 0 && amp_of(c) == 0)) begin
        t = cyc;
        break;
      end
      prev = amp_of(c);
    end
  endtask

  task automatic measure(input int c, input int p, input int k, input string tag);
    int t0, t1, t2, pe;
    pe = (p == 0) ? 1 : p;
    wait_edge(c, 1'b1, t0);
    wait_edge(c, 1'b0, t1);
    wait_edge(c, 1'b1, t2);
    chk(t1 - t0 == 8*pe*k, {tag, " high time"}, t1 - t0, 8*pe*k);
    chk(t2 - t0 == 16*pe*k, {tag, " full cycle"}, t2 - t0, 16*pe*k);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [16:0] m;
    int pl[6];
    tick(2);
    // R9: outputs silent during reset even with an open gate and full level
    mix_off = 6'h3f; vol_a = 5'd15; vol_b = 5'd15; vol_c = 5'd15;
    tick(2);
    for (int c = 0; c < 3; c++) chk(amp_of(c) == 0, "R9 reset level", amp_of(c), 0);
    rst_n = 1'b1;
    tick(2);
    for (int c = 0; c < 3; c++) chk(amp_of(c) == 15, "R9 open gate after reset", amp_of(c), 15);

    // R1 R2 R10: period sweep on all channels, distinct periods per channel
    mix_off = 6'b111000;
    pl = '{0, 1, 2, 5, 9, 14};
    foreach (pl[i]) begin
      tone_per_a = 12'(pl[i]); tone_per_b = 12'(pl[i] + 1); tone_per_c = 12'(pl[i] + 3);
      measure(0, pl[i], 1, (pl[i] == 0) ? "R2 zero period A" : "R1 tone A");
      measure(1, pl[i] + 1, 1, "R10 tone B");
      measure(2, pl[i] + 3, 1, "R10 tone C");
    end
    tone_per_a = 12'd300;
    measure(0, 300, 1, "R1 long period A");
    // R1: enable every other clock doubles the timing
    en_mode = 1;
    tone_per_b = 12'd3;
    measure(1, 3, 2, "R1 half-rate enable B");
    en_mode = 0;

    // R3: frozen enable holds the outputs
    tone_per_a = 12'd2;
    tick(40);
    en_mode = 2;
    tick(2);
    begin
      int ref_v, changes;
      ref_v = amp_of(0); changes = 0;
      for (int i = 0; i < 200; i++) begin
        tick(1);
        if (amp_of(0) != ref_v) changes++;
      end
      chk(changes == 0, "R3 frozen output", changes, 0);
      en_mode = 0;
      changes = 0;
      for (int i = 0; i < 100; i++) begin
        tick(1);
        if (amp_of(0) != ref_v) changes++;
      end
      chk(changes > 0, "R3 resumes after enable", changes, 1);
    end

    // R4 R2: noise sequence against a shift-register model, tone disabled
    foreach (pl[i]) begin
      int n, ne;
      if (i > 2) break;
      n = (i == 0) ? 1 : ((i == 1) ? 0 : 5);
      ne = (n == 0) ? 1 : n;
      mix_off = 6'b000111; noise_per = 5'(n);
      vol_a = 5'd9; vol_b = 5'd5; vol_c = 5'd15;
      do_reset();
      m = 17'h1;
      for (int k = 0; k < 20; k++) begin
        while (cyc < 16*ne*k + 8*ne) tick(1);
        chk(amp_of(0) == (m[0] ? 9 : 0), (n == 0) ? "R2 zero noise period" : "R4 noise A",
            amp_of(0), m[0] ? 9 : 0);
        chk(amp_of(1) == (m[0] ? 5 : 0), "R4 noise B", amp_of(1), m[0] ? 5 : 0);
        chk(amp_of(2) == (m[0] ? 15 : 0), "R4 noise C", amp_of(2), m[0] ? 15 : 0);
        m = lfsr_step(m);
      end
    end

    // R5 R6: every mixer setting at known tone and noise phases
    tone_per_a = 12'd3; tone_per_b = 12'd3; tone_per_c = 12'd3;
    noise_per = 5'd2;
    vol_a = 5'd11; vol_b = 5'b10011; vol_c = 5'd6; env_lvl = 4'd13;
    for (int mx = 0; mx < 64; mx++) begin
      mix_off = 6'(mx);
      do_reset();
      for (int t = 3; t < 200; t += 5) begin
        int e, tb, nb, lv[3];
        logic [5:0] mb;
        if ((t % 24) < 3 || (t % 32) < 3) continue;
        while (cyc < t) tick(1);
        e = t - 1;
        tb = (e / 24) % 2;
        m = 17'h1;
        for (int s = 0; s < e / 32; s++) m = lfsr_step(m);
        nb = int'(m[0]);
        mb = 6'(mx);
        lv = '{11, 13, 6};
        for (int c = 0; c < 3; c++) begin
          int g, ex;
          g = (tb | int'(mb[c])) & (nb | int'(mb[c+3]));
          ex = (g != 0) ? lv[c] : 0;
          chk(amp_of(c) == ex, (c == 0) ? "R5 mixer gate A" : "R6 gate and level",
              amp_of(c), ex);
        end
      end
    end

    // R7 R8: volume field decoding with the gate held open
    mix_off = 6'h3f; env_lvl = 4'd9;
    tick(2);
    for (int v = 0; v < 32; v++) begin
      int ex;
      vol_b = 5'(v);
      tick(1);
      ex = (v >= 16) ? 9 : v;
      chk(amp_b == 4'(ex), "R7 volume decode", int'(amp_b), ex);
    end
    vol_b = 5'h10;
    for (int ev = 15; ev >= 0; ev--) begin
      int old;
      old = int'(amp_b);
      env_lvl = 4'(ev);
      #1;
      chk(int'(amp_b) == old, "R8 no same-cycle change", int'(amp_b), old);
      tick(1);
      chk(amp_b == 4'(ev), "R7 envelope follow", int'(amp_b), ev);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule